// File: doc/BRIEF.md
# Warp Residency Slot Scheduler

This block keeps track of the warps resident on one multiprocessor and decides which one owns the single execution unit. It has a fixed pool of residency slots. Each slot is either empty or holds one warp. A resident warp is in one of four conditions: running, ready to run, waiting for a memory return, or waiting at a workgroup barrier. A dispatcher places new warps into empty slots, tagging each one with a workgroup number. The running warp reports, through three strobes, whether it finished, stalled on memory or reached a barrier. The memory system hands back completions tagged with the slot that asked for them.

Switching warps costs nothing. In the same cycle that the running warp leaves, the scheduler picks a successor from the ready slots in round-robin order, and that successor runs in the next cycle. Barriers are tracked per workgroup. Warps of a workgroup stay parked until every warp of that workgroup still resident has arrived, and workgroups never hold each other up. A counter records the cycles spent without any running warp.

Top module: `warp_sched`

## Requirements
- R1: While reset is held and right after it, every slot is empty, `activeValid` is 0, `slotFree` is all zeros and `idleCount` is 0.
- R2: A pulse on `allocValid` places a warp with workgroup `allocWg` into the lowest-numbered empty slot, and that warp can be issued from the following cycle onward. When no slot is empty, the pulse is dropped and no resident warp is affected.
- R3: At most one warp runs at a time. The running warp keeps `activeSlot` and `activeValid` unchanged until it raises `done`, `blockMem` or `blockBar`.
- R4: When the running warp leaves and at least one slot is ready in that cycle, `activeValid` stays 1 in the next cycle with the new slot, so no cycle is lost.
- R5: The next warp is the first ready slot found by searching upward from the slot after the last one issued, wrapping from the top slot to slot 0. After reset, the search starts at slot 0.
- R6: A warp that raised `blockMem` waits until `memRetValid` arrives with `memRetSlot` equal to its slot. One cycle later it is ready. It never displaces the running warp. A memory return naming a slot that is not waiting on memory changes nothing.
- R7: A warp that raised `blockBar` waits at its workgroup's barrier. When the number of arrived warps equals the number of warps of that workgroup still resident, all of them become ready one cycle later and the arrival count returns to zero. Warps of other workgroups are unaffected.
- R8: When the running warp raises `done`, its slot becomes empty. `slotFree` then shows a one-cycle pulse on the bit for that slot (bit n is slot n) in the next cycle. A completion that leaves only barrier-waiting warps in its workgroup releases them as in R7.
- R9: `idleCount` goes up by one at every clock edge at which `activeValid` was 0.
- R10: If the running warp raises several strobes in one cycle, `done` wins over `blockBar`, and `blockBar` wins over `blockMem`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| allocValid | input | 1 | Request to place a new warp |
| allocWg | input | WG_W | Workgroup number of the new warp |
| done | input | 1 | Running warp has finished |
| blockMem | input | 1 | Running warp stalls on a memory access |
| blockBar | input | 1 | Running warp reached a barrier |
| memRetValid | input | 1 | Memory return event |
| memRetSlot | input | $clog2(SLOTS) | Slot the memory return belongs to |
| activeValid | output | 1 | A warp owns the execution unit |
| activeSlot | output | $clog2(SLOTS) | Slot of the running warp |
| slotFree | output | SLOTS | One-cycle pulse per slot that was just vacated |
| idleCount | output | IDLE_W | Cycles without a running warp |

## Verification
The assertions check, on every cycle, the invariants that do not depend on how warps move around. They cover a single running warp whose slot matches `activeSlot`, a running warp that stays put while it raises no strobe, a gapless handover whenever a ready slot exists, a one-hot free pulse on the slot that just finished, and the idle counter's step. Other properties can only be seen through the bench's scenarios. These are the order of round-robin selection, which warp a memory return or barrier release wakes, the barrier counts kept apart between workgroups, a completion that finishes a barrier, the priority among simultaneous strobes, and an allocation dropped when all slots are full.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

  typedef enum logic [2:0] {
    ST_EMPTY    = 3'd0,
    ST_READY    = 3'd1,
    ST_ACTIVE   = 3'd2,
    ST_WAIT_MEM = 3'd3,
    ST_WAIT_BAR = 3'd4
  } slotState_t;

  typedef enum logic [1:0] {
    LV_NONE = 2'd0,
    LV_DONE = 2'd1,
    LV_MEM  = 2'd2,
    LV_BAR  = 2'd3
  } leaveKind_t;

  typedef struct packed {
    logic       issue;
    leaveKind_t leaveKind;
  } schedStrobe_t;

endpackage

// File: rtl/warp_sched_ctrl.sv
module warp_sched_ctrl
  import warp_sched_pkg::*;
#(
  parameter int SLOTS  = 16,
  parameter int IDX_W  = 4,
  parameter int IDLE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic              blockMem,
  input  logic              blockBar,
  input  logic [SLOTS-1:0]  readyMask,
  output schedStrobe_t      strb,
  output logic [IDX_W-1:0]  issueSlot,
  output logic              activeValid,
  output logic [IDX_W-1:0]  activeSlot,
  output logic [IDLE_W-1:0] idleCount
);

  logic [IDX_W-1:0] lastSlot;
  logic             leaving;
  logic             canIssue;
  logic             found;
  logic [IDX_W-1:0] pickIdx;

  // Strobe priority: completion, then barrier, then memory stall
  always_comb begin
    strb.leaveKind = LV_NONE;
    if (activeValid) begin
      if (done)          strb.leaveKind = LV_DONE;
      else if (blockBar) strb.leaveKind = LV_BAR;
      else if (blockMem) strb.leaveKind = LV_MEM;
    end
    leaving  = (strb.leaveKind != LV_NONE);
    canIssue = !activeValid || leaving;
  end

  // Round-robin search from the slot after the last one issued
  always_comb begin
    found   = 1'b0;
    pickIdx = '0;
    for (int i = 1; i <= SLOTS; i++) begin
      int cand;
      cand = int'(lastSlot) + i;
      if (cand >= SLOTS) cand = cand - SLOTS;
      if (!found && readyMask[cand]) begin
        found   = 1'b1;
        pickIdx = IDX_W'(cand);
      end
    end
    strb.issue = canIssue && found;
    issueSlot  = pickIdx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activeValid <= 1'b0;
      activeSlot  <= '0;
      lastSlot    <= IDX_W'(SLOTS - 1);
      idleCount   <= '0;
    end else begin
      if (strb.issue) begin
        activeValid <= 1'b1;
        activeSlot  <= pickIdx;
        lastSlot    <= pickIdx;
      end else if (leaving) begin
        activeValid <= 1'b0;
      end
      if (!activeValid) idleCount <= idleCount + IDLE_W'(1);
    end
  end

endmodule

// File: rtl/warp_sched_slots.sv
module warp_sched_slots
  import warp_sched_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int IDX_W = 4,
  parameter int WG_W  = 2,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             allocValid,
  input  logic [WG_W-1:0]  allocWg,
  input  logic             memRetValid,
  input  logic [IDX_W-1:0] memRetSlot,
  input  schedStrobe_t     strb,
  input  logic [IDX_W-1:0] issueSlot,
  input  logic [IDX_W-1:0] leaveSlot,
  output logic [SLOTS-1:0] readyMask,
  output logic [SLOTS-1:0] activeMask,
  output logic [SLOTS-1:0] slotFree
);

  localparam int NUM_WG = 1 << WG_W;

  slotState_t      st        [SLOTS];
  logic [WG_W-1:0] wgOf      [SLOTS];
  logic [CNT_W-1:0] arrived  [NUM_WG];
  logic [CNT_W-1:0] residentCnt [NUM_WG];
  logic [NUM_WG-1:0] relWg;
  logic [SLOTS-1:0]  emptyMask;
  logic              allocHit;
  logic [IDX_W-1:0]  allocIdx;
  logic              leaving;
  logic [WG_W-1:0]   leaveWg;

  assign leaving = (strb.leaveKind != LV_NONE);
  assign leaveWg = wgOf[leaveSlot];

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_mask
      assign emptyMask[s]  = (st[s] == ST_EMPTY);
      assign readyMask[s]  = (st[s] == ST_READY);
      assign activeMask[s] = (st[s] == ST_ACTIVE);
    end
  endgenerate

  // Lowest-numbered empty slot takes a new warp
  always_comb begin
    allocHit = 1'b0;
    allocIdx = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (!allocHit && emptyMask[s]) begin
        allocHit = 1'b1;
        allocIdx = IDX_W'(s);
      end
    end
  end

  // Barrier bookkeeping: resident warps per workgroup versus arrivals
  always_comb begin
    for (int g = 0; g < NUM_WG; g++) begin
      residentCnt[g] = '0;
      for (int s = 0; s < SLOTS; s++) begin
        if (st[s] != ST_EMPTY && wgOf[s] == WG_W'(g))
          residentCnt[g] = residentCnt[g] + CNT_W'(1);
      end
      relWg[g] = (arrived[g] != '0) && (arrived[g] == residentCnt[g]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NUM_WG; g++) arrived[g] <= '0;
    end else begin
      for (int g = 0; g < NUM_WG; g++) begin
        if (relWg[g])
          arrived[g] <= '0;
        else if (strb.leaveKind == LV_BAR && leaveWg == WG_W'(g))
          arrived[g] <= arrived[g] + CNT_W'(1);
      end
    end
  end

  // Per-slot state transitions
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) begin
        st[s]   <= ST_EMPTY;
        wgOf[s] <= '0;
      end
      slotFree <= '0;
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        slotFree[s] <= leaving && (strb.leaveKind == LV_DONE) && (leaveSlot == IDX_W'(s));
        if (leaving && leaveSlot == IDX_W'(s)) begin
          case (strb.leaveKind)
            LV_DONE: st[s] <= ST_EMPTY;
            LV_BAR:  st[s] <= ST_WAIT_BAR;
            default: st[s] <= ST_WAIT_MEM;
          endcase
        end else if (strb.issue && issueSlot == IDX_W'(s)) begin
          st[s] <= ST_ACTIVE;
        end else if (allocValid && allocHit && allocIdx == IDX_W'(s)) begin
          st[s]   <= ST_READY;
          wgOf[s] <= allocWg;
        end else if (st[s] == ST_WAIT_MEM && memRetValid && memRetSlot == IDX_W'(s)) begin
          st[s] <= ST_READY;
        end else if (st[s] == ST_WAIT_BAR && relWg[wgOf[s]]) begin
          st[s] <= ST_READY;
        end
      end
    end
  end

endmodule

// File: rtl/warp_sched.sv
module warp_sched
  import warp_sched_pkg::*;
#(
  parameter int SLOTS  = 16,
  parameter int WG_W   = 2,
  parameter int IDLE_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     allocValid,
  input  logic [WG_W-1:0]          allocWg,
  input  logic                     done,
  input  logic                     blockMem,
  input  logic                     blockBar,
  input  logic                     memRetValid,
  input  logic [$clog2(SLOTS)-1:0] memRetSlot,
  output logic                     activeValid,
  output logic [$clog2(SLOTS)-1:0] activeSlot,
  output logic [SLOTS-1:0]         slotFree,
  output logic [IDLE_W-1:0]        idleCount
);

  localparam int IDX_W = $clog2(SLOTS);
  localparam int CNT_W = $clog2(SLOTS + 1);

  schedStrobe_t     strb;
  logic [IDX_W-1:0] issueSlot;
  logic [SLOTS-1:0] readyMask;
  logic [SLOTS-1:0] activeMask;

  warp_sched_ctrl #(
    .SLOTS(SLOTS), .IDX_W(IDX_W), .IDLE_W(IDLE_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .done(done), .blockMem(blockMem), .blockBar(blockBar),
    .readyMask(readyMask),
    .strb(strb), .issueSlot(issueSlot),
    .activeValid(activeValid), .activeSlot(activeSlot),
    .idleCount(idleCount)
  );

  warp_sched_slots #(
    .SLOTS(SLOTS), .IDX_W(IDX_W), .WG_W(WG_W), .CNT_W(CNT_W)
  ) u_slots (
    .clk(clk), .rst_n(rst_n),
    .allocValid(allocValid), .allocWg(allocWg),
    .memRetValid(memRetValid), .memRetSlot(memRetSlot),
    .strb(strb), .issueSlot(issueSlot), .leaveSlot(activeSlot),
    .readyMask(readyMask), .activeMask(activeMask),
    .slotFree(slotFree)
  );

endmodule

// File: rtl/warp_sched_chk.sv
module warp_sched_chk #(
  parameter int SLOTS  = 16,
  parameter int IDX_W  = 4,
  parameter int IDLE_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              blockMem,
  input logic              blockBar,
  input logic              activeValid,
  input logic [IDX_W-1:0]  activeSlot,
  input logic [SLOTS-1:0]  slotFree,
  input logic [IDLE_W-1:0] idleCount,
  input logic [SLOTS-1:0]  readyMask,
  input logic [SLOTS-1:0]  activeMask
);

  p_single_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(activeMask));

  p_slot_matches_r3: assert property (@(posedge clk) disable iff (!rst_n)
    activeValid |-> activeMask[activeSlot]);

  p_hold_running_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (activeValid && !done && !blockMem && !blockBar) |=> (activeValid && $stable(activeSlot)));

  p_zero_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (activeValid && (done || blockMem || blockBar) && (readyMask != '0)) |=> activeValid);

  p_free_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slotFree));

  p_free_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (activeValid && done) |=> (slotFree == (SLOTS'(1) << $past(activeSlot))));

  p_idle_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !activeValid |=> (idleCount == $past(idleCount) + IDLE_W'(1)));

endmodule

bind warp_sched warp_sched_chk #(
  .SLOTS(SLOTS), .IDX_W(IDX_W), .IDLE_W(IDLE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .done(done), .blockMem(blockMem), .blockBar(blockBar),
  .activeValid(activeValid), .activeSlot(activeSlot),
  .slotFree(slotFree), .idleCount(idleCount),
  .readyMask(readyMask), .activeMask(activeMask)
);

// File: tb/warp_sched_tb.sv
`timescale 1ns/1ps
module warp_sched_tb;

  localparam int SLOTS  = 16;
  localparam int WG_W   = 2;
  localparam int IDLE_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              allocValid = 1'b0;
  logic [WG_W-1:0]   allocWg = '0;
  logic              done = 1'b0;
  logic              blockMem = 1'b0;
  logic              blockBar = 1'b0;
  logic              memRetValid = 1'b0;
  logic [3:0]        memRetSlot = '0;
  logic              activeValid;
  logic [3:0]        activeSlot;
  logic [SLOTS-1:0]  slotFree;
  logic [IDLE_W-1:0] idleCount;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  typedef struct {
    int          due;
    logic        eV;
    logic [3:0]  eS;
    logic [15:0] eFree;
    string       tag;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  warp_sched #(.SLOTS(SLOTS), .WG_W(WG_W), .IDLE_W(IDLE_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .allocValid(allocValid), .allocWg(allocWg),
    .done(done), .blockMem(blockMem), .blockBar(blockBar),
    .memRetValid(memRetValid), .memRetSlot(memRetSlot),
    .activeValid(activeValid), .activeSlot(activeSlot),
    .slotFree(slotFree), .idleCount(idleCount)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Monitor: pops expectations that fall due at this falling edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      it = sb.pop_front();
      check({it.tag, " activeValid"}, 32'(activeValid), 32'(it.eV));
      if (it.eV) check({it.tag, " activeSlot"}, 32'(activeSlot), 32'(it.eS));
      check({it.tag, " slotFree"}, 32'(slotFree), 32'(it.eFree));
    end
  end

  // Driver: apply one cycle of stimulus, queue the expected result
  task automatic step(input logic aV, input logic [1:0] aWg, input logic dn,
                      input logic bm, input logic bb, input logic mV,
                      input logic [3:0] mS, input logic eV, input logic [3:0] eS,
                      input logic [15:0] eFree, input string tag);
    item_t it;
    allocValid = aV; allocWg = aWg; done = dn; blockMem = bm; blockBar = bb;
    memRetValid = mV; memRetSlot = mS;
    it.due = cyc + 1; it.eV = eV; it.eS = eS; it.eFree = eFree; it.tag = tag;
    sb.push_back(it);
    @(posedge clk);
    @(negedge clk);
    allocValid = 0; done = 0; blockMem = 0; blockBar = 0; memRetValid = 0;
  endtask

  task automatic doReset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 reset activeValid", 32'(activeValid), 32'd0);
    check("R1 reset slotFree", 32'(slotFree), 32'd0);
    check("R1 reset idleCount", idleCount, 32'd0);
    rst_n = 1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [IDLE_W-1:0] idleSnap;
    doReset();
    // Phase 1: mixed blocking, barriers and round robin
    step(1,0,0,0,0,0,0, 0,0,16'h0,    "R2 first alloc not yet issued");
    step(1,0,0,0,0,0,0, 1,0,16'h0,    "R2 slot0 issued");
    step(1,1,0,0,0,0,0, 1,0,16'h0,    "R3 running warp held");
    step(0,0,0,0,0,0,0, 1,0,16'h0,    "R3 running warp held");
    step(0,0,0,1,0,0,0, 1,1,16'h0,    "R5 rr after slot0");
    step(0,0,0,1,1,0,0, 1,2,16'h0,    "R10 R4 bar beats mem");
    step(0,0,0,0,0,1,0, 1,2,16'h0,    "R6 no preempt on return");
    step(0,0,1,0,0,0,0, 1,0,16'h0004, "R8 done frees slot2");
    step(0,0,0,0,0,0,0, 1,0,16'h0,    "R8 free pulse one cycle");
    idleSnap = idleCount;
    step(0,0,0,0,1,0,0, 0,0,16'h0,    "R7 barrier wait");
    step(0,0,0,0,0,0,0, 0,0,16'h0,    "R7 release in flight");
    step(0,0,0,0,0,0,0, 1,1,16'h0,    "R7 R5 released rr");
    check("R9 idle count", idleCount, idleSnap + 32'd2);
    step(0,0,1,0,0,0,0, 1,0,16'h0002, "R5 R8 rr wrap");
    step(1,1,0,0,0,0,0, 1,0,16'h0,    "R2 refill slot1");
    step(1,1,0,0,0,0,0, 1,0,16'h0,    "R2 refill slot2");
    step(0,0,0,0,1,0,0, 1,1,16'h0,    "R4 lone warp barrier");
    step(0,0,0,0,0,0,0, 1,1,16'h0,    "R7 lone warp released");
    step(0,0,0,0,1,0,0, 1,2,16'h0,    "R5 next after slot1");
    step(0,0,0,1,0,0,0, 1,0,16'h0,    "R7 other group ready");
    step(0,0,0,1,0,0,0, 0,0,16'h0,    "R7 group1 held");
    step(0,0,0,0,0,1,2, 0,0,16'h0,    "R6 return slot2");
    step(0,0,0,0,0,0,0, 1,2,16'h0,    "R6 slot2 reissued");
    step(0,0,1,0,0,0,0, 0,0,16'h0004, "R8 done completes barrier");
    step(0,0,0,0,0,0,0, 0,0,16'h0,    "R8 release in flight");
    step(0,0,0,0,0,0,0, 1,1,16'h0,    "R7 R8 slot1 released");
    // Phase 2: fill all slots, overflow allocation, drain
    doReset();
    step(1,3,0,0,0,0,0, 0,0,16'h0, "R2 fill");
    for (int k = 1; k < 16; k++) step(1,3,0,0,0,0,0, 1,0,16'h0, "R2 fill");
    step(1,3,0,0,0,0,0, 1,0,16'h0, "R2 full alloc dropped");
    step(0,0,1,1,0,0,0, 1,1,16'h0001, "R10 done beats mem");
    for (int k = 1; k < 15; k++)
      step(0,0,1,0,0,0,0, 1,4'(k+1),16'(1 << k), "R8 drain");
    step(0,0,1,0,0,0,0, 0,0,16'h8000, "R2 R8 last slot drained");
    step(0,0,0,0,0,0,0, 0,0,16'h0,    "R2 dropped warp absent");
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule